// File: doc/BRIEF.md
# Configurable I2S Serial Transmitter

This block turns audio samples from a show-ahead transmit FIFO into a three-wire serial stream: a bit clock, a word clock that marks the left and right channel, and serial data. Software settings choose the frame alignment (standard, left-justified or right-justified), the sample width (8 or 16 bits), stereo or mono, and the frame length (32, 64 or 128 bit clocks per word-clock period). Settings are meant to change only while the transmitter is stopped.

As clock master the block divides the system clock to make its own bit clock and word clock. As slave it synchronizes an external bit clock and word clock, and takes each word-clock change as the start of a channel. A loopback switch sends the transmit data line to the receive data input, so a receiver can be tested without wiring. If the FIFO is empty when a sample is due, the block sends zeros and raises a sticky underrun flag.

Top module: `i2s_tx_serializer`

## Requirements
- R1: After reset, with `tx_start` low and master mode selected, `bclk_out` and `wclk_out` are 1, `sdata_out` is 0, `fifo_pop` is 0 and `underrun` is 0.
- R2: In master mode each half period of `bclk_out` lasts `cfg_div`+1 clock cycles. `wclk_out` and `sdata_out` change only on falling bit-clock edges. `wclk_out` is 0 for the left half-frame and 1 for the right half-frame, and each half lasts half the frame length.
- R3: `cfg_ratio` gives the bit clocks per frame: 0 gives 32, 1 gives 64, 2 gives 128. The reserved code 3 behaves as 32.
- R4: With `cfg_align`=0 (standard; the reserved code 3 behaves the same way) the MSB of each channel is sent in the second bit slot of its half-frame. With a 16-bit sample in a 32-slot frame, the right LSB falls into slot 0 of the next frame.
- R5: With `cfg_align`=1 (left-justified) the MSB is sent in the first bit slot of its half-frame.
- R6: With `cfg_align`=2 (right-justified) the LSB is sent in the last bit slot of its half-frame.
- R7: `cfg_wide`=1 sends all 16 bits of `fifo_data`. `cfg_wide`=0 sends only `fifo_data[7:0]`. Both are sent MSB first.
- R8: Every bit slot that carries no sample bit is driven to 0.
- R9: With `cfg_mono`=1 one FIFO entry is used per frame and sent in the left slot only. The right half-frame carries zeros.
- R10: Samples are taken from the FIFO in order, one `fifo_pop` per sample. When a sample is due while `fifo_empty` is 1, zeros are sent and `underrun` is set. It stays set until reset or `tx_reset`.
- R11: With `cfg_master`=0 the block follows `bclk_in` and `wclk_in`: data changes after each falling `bclk_in`, and a `wclk_in` change marks slot 0 of a channel (0 = left). `bclk_out` and `wclk_out` stay at 0.
- R12: `rx_sdata` equals `sdata_out` when `cfg_loopback` is 1, and `rx_sdata_pin` otherwise.
- R13: While `tx_start` is low or `tx_reset` is high the transmitter is idle: no pops, `sdata_out` is 0, and the master bit clock rests at 1. `tx_reset` also clears `underrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_start | input | 1 | Run the transmitter |
| tx_reset | input | 1 | Hold the transmitter idle and clear the underrun flag |
| cfg_master | input | 1 | 1 = generate the clocks, 0 = follow external clocks |
| cfg_align | input | 2 | 0 standard, 1 left-justified, 2 right-justified |
| cfg_ratio | input | 2 | Bit clocks per frame: 0→32, 1→64, 2→128, 3→32 |
| cfg_wide | input | 1 | 0 = 8-bit samples, 1 = 16-bit samples |
| cfg_mono | input | 1 | Send left channel only |
| cfg_div | input | DIV_W | Bit-clock half period minus one, in clock cycles |
| cfg_loopback | input | 1 | Route the transmit data to the receive input |
| fifo_empty | input | 1 | FIFO has no entry |
| fifo_data | input | SAMPLE_W | Head entry of the show-ahead FIFO |
| fifo_pop | output | 1 | Consume the head entry at this clock edge |
| bclk_in | input | 1 | External bit clock (slave mode) |
| wclk_in | input | 1 | External word clock (slave mode) |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| wclk_out | output | 1 | Generated word clock (master mode) |
| sdata_out | output | 1 | Serial data |
| rx_sdata_pin | input | 1 | Serial data from the receive pin |
| rx_sdata | output | 1 | Data presented to the receiver |
| underrun | output | 1 | Sticky: a sample was due while the FIFO was empty |

## Verification
The bench targets the alignment edges. If standard mode dropped its one-slot delay, every word would decode shifted by one bit. If the 16-bit right LSB in a 32-slot frame were not carried into the next frame, the right words would come out with a wrong LSB. If right-justified data were placed at the wrong end of the half-frame, non-zero bits would show up in slots that must be zero. Mono mode and FIFO drain are also targeted. A design that popped in the right slot, or that sent stale data instead of zeros on underrun, would break the decoded word order. The reserved frame-length code must act as 32 slots, and slave mode must lock on the first word-clock change.

// File: rtl/i2stx_pkg.sv
// Package: shared constants, frame-alignment codes and frame-length decode
// for the serial audio transmitter. Assumes a frame of at most 128 slots.
package i2stx_pkg;

    localparam int SAMPLE_W = 16;                 // widest sample
    localparam int NARROW_W = 8;                  // narrow sample
    localparam int IDX_W    = $clog2(SAMPLE_W);   // bit index inside a sample
    localparam int POS_W    = 7;                  // slot position in a frame

    typedef enum logic [1:0] {
        ALIGN_STD   = 2'd0,
        ALIGN_LEFT  = 2'd1,
        ALIGN_RIGHT = 2'd2,
        ALIGN_RSVD  = 2'd3
    } align_e;

    // Last slot index of a frame for a ratio code (reserved code acts as 32).
    function automatic logic [POS_W-1:0] last_slot(input logic [1:0] code);
        case (code)
            2'd1:    return 7'd63;
            2'd2:    return 7'd127;
            default: return 7'd31;
        endcase
    endfunction

    // Slot count of one half-frame for a ratio code.
    function automatic logic [POS_W-1:0] half_slots(input logic [1:0] code);
        case (code)
            2'd1:    return 7'd32;
            2'd2:    return 7'd64;
            default: return 7'd16;
        endcase
    endfunction

endpackage

// File: rtl/i2stx_clkgen.sv
// Clock front end: in master mode divides clk into a bit clock, in slave
// mode synchronizes the external bit and word clocks. Either way it emits
// a one-cycle tick for every falling bit-clock edge. Assumes SYNC_N >= 2.
module i2stx_clkgen #(
    parameter int DIV_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             master,
    input  logic [DIV_W-1:0] div,
    input  logic             bclk_in,
    input  logic             wclk_in,
    output logic             tick,
    output logic             wclk_ext,
    output logic             bclk_out
);

    logic [DIV_W-1:0] cnt;
    logic             bclk_q;
    logic [SYNC_N:0]  bsync;
    logic [SYNC_N-1:0] wsync;

    // Divider: toggles the master bit clock every div+1 cycles, rests high.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !master) begin
            cnt    <= '0;
            bclk_q <= 1'b1;
        end else if (cnt == div) begin
            cnt    <= '0;
            bclk_q <= ~bclk_q;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    // Synchronizers for the external clocks; the bit clock keeps one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bsync <= '1;
            wsync <= '1;
        end else begin
            bsync <= {bsync[SYNC_N-1:0], bclk_in};
            wsync <= {wsync[SYNC_N-2:0], wclk_in};
        end
    end

    assign wclk_ext = wsync[SYNC_N-1];
    assign tick     = run && (master ? (cnt == div && bclk_q)
                                     : (bsync[SYNC_N] && !bsync[SYNC_N-1]));
    assign bclk_out = master && bclk_q;

    // R13: one cycle after an idle cycle the master bit clock rests high.
    p_bclk_rest_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (master && !$past(run)) |-> bclk_out);

endmodule

// File: rtl/i2stx_framer.sv
// Frame position tracker: keeps the slot index inside the frame, makes the
// master word clock, and for the next slot works out the channel, whether
// it carries a sample bit, and which bit. Assumes settings are stable while
// running.
module i2stx_framer
    import i2stx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             master,
    input  logic             tick,
    input  logic             wclk_ext,
    input  logic [1:0]       ratio_code,
    input  logic [1:0]       align,
    input  logic             wide,
    output logic             wclk_q,
    output logic             chan_q,
    output logic             chan_n,
    output logic             slot_first,
    output logic             bit_valid,
    output logic [IDX_W-1:0] bit_idx
);

    logic [POS_W-1:0] pos, pos_n, q, s, last, half, wlen;
    logic             wprev, delay1;

    assign last   = last_slot(ratio_code);
    assign half   = half_slots(ratio_code);
    assign wlen   = wide ? POS_W'(SAMPLE_W) : POS_W'(NARROW_W);
    assign delay1 = !(align == ALIGN_LEFT || align == ALIGN_RIGHT);

    // Next slot index: free-running in master, resynced to word-clock changes in slave.
    always_comb begin
        if (!master && (wclk_ext != wprev))
            pos_n = wclk_ext ? half : '0;
        else if (pos >= last)
            pos_n = '0;
        else
            pos_n = pos + 1'b1;
    end

    // Data slot of the next bit: the standard format lags the word clock by one slot.
    always_comb begin
        if (delay1 && pos_n == '0) q = last;
        else if (delay1)           q = pos_n - 1'b1;
        else                       q = pos_n;
        chan_n     = (q >= half);
        s          = chan_n ? q - half : q;
        slot_first = (s == '0);
        if (align == ALIGN_RIGHT) begin
            bit_valid = (s >= half - wlen);
            bit_idx   = IDX_W'(half - 1'b1 - s);
        end else begin
            bit_valid = (s < wlen);
            bit_idx   = IDX_W'(wlen - 1'b1 - s);
        end
    end

    // Position, word clock and channel registers advance on each falling-edge tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pos    <= last;
            wprev  <= 1'b1;
            wclk_q <= 1'b1;
            chan_q <= 1'b1;
        end else if (tick) begin
            pos    <= pos_n;
            wprev  <= wclk_ext;
            wclk_q <= (pos_n >= half);
            chan_q <= chan_n;
        end
    end

    // R3: the slot index never leaves the selected frame length while running.
    p_pos_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (pos <= last));

endmodule

// File: rtl/i2stx_shifter.sv
// Sample holder and serial output: loads a FIFO entry (or zeros on
// underrun) at the first slot of each channel that needs one, and drives
// the selected bit or 0 on each tick. Assumes a show-ahead FIFO.
module i2stx_shifter
    import i2stx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                flag_clr,
    input  logic                tick,
    input  logic                wide,
    input  logic                mono,
    input  logic                slot_first,
    input  logic                chan_n,
    input  logic                chan_q,
    input  logic                bit_valid,
    input  logic [IDX_W-1:0]    bit_idx,
    input  logic                fifo_empty,
    input  logic [SAMPLE_W-1:0] fifo_data,
    output logic                fifo_pop,
    output logic                sdata,
    output logic                underrun
);

    localparam logic [SAMPLE_W-1:0] LOW_MASK =
        {{(SAMPLE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic [SAMPLE_W-1:0] shreg, shreg_n, masked;
    logic                need, load, silent;

    assign silent   = mono && chan_n;
    assign need     = slot_first && !silent;
    assign load     = tick && need;
    assign fifo_pop = load && !fifo_empty;
    assign masked   = wide ? fifo_data : (fifo_data & LOW_MASK);
    assign shreg_n  = need ? (fifo_empty ? '0 : masked) : shreg;

    // Holds the current sample and registers the outgoing bit on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            shreg <= '0;
            sdata <= 1'b0;
        end else if (tick) begin
            shreg <= shreg_n;
            sdata <= (bit_valid && !silent) ? shreg_n[bit_idx] : 1'b0;
        end
    end

    // Sticky underrun flag, cleared by reset or the transmitter reset bit.
    always_ff @(posedge clk) begin
        if (!rst_n || flag_clr)
            underrun <= 1'b0;
        else if (load && fifo_empty)
            underrun <= 1'b1;
    end

    // R2: the data line moves only after a falling-edge tick or when stopping.
    p_data_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata) |-> ($past(tick) || !$past(run)));
    // R9: in mono mode the right half-frame carries zeros.
    p_mono_right_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mono && chan_q) |-> !sdata);
    // R10: at most one pop per bit slot, never on adjacent cycles.
    p_pop_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop);
    // R10: the underrun flag rises only after a tick that found the FIFO empty.
    p_underrun_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> ($past(fifo_empty) && $past(tick)));

endmodule

// File: rtl/i2s_tx_serializer.sv
// Top of the serial audio transmitter: clock front end, frame tracker and
// sample shifter, plus the loopback switch to the receive data input.
// Assumes configuration inputs change only while tx_start is low.
module i2s_tx_serializer
    import i2stx_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_start,
    input  logic                tx_reset,
    input  logic                cfg_master,
    input  logic [1:0]          cfg_align,
    input  logic [1:0]          cfg_ratio,
    input  logic                cfg_wide,
    input  logic                cfg_mono,
    input  logic [DIV_W-1:0]    cfg_div,
    input  logic                cfg_loopback,
    input  logic                fifo_empty,
    input  logic [SAMPLE_W-1:0] fifo_data,
    output logic                fifo_pop,
    input  logic                bclk_in,
    input  logic                wclk_in,
    output logic                bclk_out,
    output logic                wclk_out,
    output logic                sdata_out,
    input  logic                rx_sdata_pin,
    output logic                rx_sdata,
    output logic                underrun
);

    logic             run, tick, wclk_ext, wclk_q, chan_q, chan_n;
    logic             slot_first, bit_valid;
    logic [IDX_W-1:0] bit_idx;

    assign run = tx_start && !tx_reset;

    i2stx_clkgen #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(run), .master(cfg_master), .div(cfg_div),
        .bclk_in(bclk_in), .wclk_in(wclk_in), .tick(tick), .wclk_ext(wclk_ext),
        .bclk_out(bclk_out)
    );

    i2stx_framer u_frm (
        .clk(clk), .rst_n(rst_n), .run(run), .master(cfg_master), .tick(tick),
        .wclk_ext(wclk_ext), .ratio_code(cfg_ratio), .align(cfg_align),
        .wide(cfg_wide), .wclk_q(wclk_q), .chan_q(chan_q), .chan_n(chan_n),
        .slot_first(slot_first), .bit_valid(bit_valid), .bit_idx(bit_idx)
    );

    i2stx_shifter u_shf (
        .clk(clk), .rst_n(rst_n), .run(run), .flag_clr(tx_reset), .tick(tick),
        .wide(cfg_wide), .mono(cfg_mono), .slot_first(slot_first),
        .chan_n(chan_n), .chan_q(chan_q), .bit_valid(bit_valid),
        .bit_idx(bit_idx), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_pop(fifo_pop), .sdata(sdata_out), .underrun(underrun)
    );

    // Word clock leaves the block only in master mode.
    assign wclk_out  = cfg_master && wclk_q;
    // Loopback switch in front of the receiver.
    assign rx_sdata  = cfg_loopback ? sdata_out : rx_sdata_pin;

endmodule

// File: tb/i2s_tx_serializer_tb_top.sv
`timescale 1ns/1ps
module i2s_tx_serializer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_start = 1'b0, tx_reset = 1'b0;
    logic        cfg_master = 1'b1, cfg_wide = 1'b1, cfg_mono = 1'b0, cfg_loopback = 1'b0;
    logic [1:0]  cfg_align = 2'd0, cfg_ratio = 2'd0;
    logic [7:0]  cfg_div = 8'd1;
    logic        fifo_empty = 1'b1;
    logic [15:0] fifo_data = 16'h0;
    logic        fifo_pop;
    logic        bclk_in = 1'b1, wclk_in = 1'b1;
    logic        bclk_out, wclk_out, sdata_out, rx_sdata, underrun;
    logic        rx_sdata_pin = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    i2s_tx_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_reset(tx_reset),
        .cfg_master(cfg_master), .cfg_align(cfg_align), .cfg_ratio(cfg_ratio),
        .cfg_wide(cfg_wide), .cfg_mono(cfg_mono), .cfg_div(cfg_div),
        .cfg_loopback(cfg_loopback), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_pop(fifo_pop), .bclk_in(bclk_in), .wclk_in(wclk_in),
        .bclk_out(bclk_out), .wclk_out(wclk_out), .sdata_out(sdata_out),
        .rx_sdata_pin(rx_sdata_pin), .rx_sdata(rx_sdata), .underrun(underrun)
    );

    int checks = 0, fails = 0;
    logic [15:0] feed[$];   // FIFO model contents
    logic [15:0] expq[$];   // scoreboard of expected words

    // bench model of the current settings
    int  fr_len = 32, hlen = 16, wbits = 16, dv = 1;
    bit  std_al = 1, rj_al = 0, mono_m = 0, mon_m = 0, lb_on = 0;
    bit  fb[128], wb[128];
    int  p = 0, frames = 0, cyc = 0, last_edge = 0;
    bit  prev_w = 1, have = 0, per_done = 0, last_b = 1, slave_clk_done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // decode one finished frame against the scoreboard
    task automatic decode(input bit spill);
        bit mark[128];
        int ones;
        string areq;
        areq = rj_al ? "R6" : (std_al ? "R4" : "R5");
        for (int g = 0; g < 128; g++) mark[g] = 0;
        for (int ch = 0; ch < 2; ch++) begin
            logic [15:0] word, expv;
            word = 0;
            for (int k = 0; k < wbits; k++) begin
                int g;
                bit b;
                g = ch * hlen + (rj_al ? (hlen - wbits + k) : (k + (std_al ? 1 : 0)));
                b = (g < fr_len) ? fb[g] : spill;
                mark[g % fr_len] = 1;
                word = {word[14:0], b};
            end
            if (ch == 1 && mono_m) expv = 0;
            else expv = (expq.size() > 0) ? expq.pop_front() : 16'h0;
            chk(word == expv, $sformatf("%s%s%s%s ch%0d", areq, (wbits == 8) ? " R7" : "",
                (ch == 1 && mono_m) ? " R9" : "", (expv == 0) ? " R10" : "", ch),
                word, expv);
        end
        ones = 0;
        for (int g = 0; g < fr_len; g++) if (!mark[g] && fb[g]) ones++;
        chk(ones == 0, "R8 unused slots", ones, 0);
        if (mon_m) begin
            int hi;
            hi = 0;
            for (int g = 0; g < fr_len; g++) hi += wb[g];
            chk(hi == hlen && wb[hlen-1] == 0 && wb[hlen] == 1, "R2 R3 word clock",
                hi, hlen);
        end
        frames++;
    endtask

    // monitor: one call per rising bit clock
    task automatic observe(input bit b, input bit w);
        if (prev_w && !w) begin
            if (have) decode(b);
            have = 1;
            p = 0;
            for (int g = 0; g < 128; g++) begin fb[g] = 0; wb[g] = 0; end
        end else begin
            p++;
        end
        if (p < 128) begin fb[p] = b; wb[p] = w; end
        prev_w = w;
        if (lb_on) chk(rx_sdata == b, "R12 loopback", rx_sdata, b);
        if (!mon_m && !slave_clk_done) begin
            chk(bclk_out == 0 && wclk_out == 0, "R11 clock outputs low",
                {bclk_out, wclk_out}, 0);
            slave_clk_done = 1;
        end
    endtask

    // FIFO model: pop at the edge, present the new head mid-cycle
    always @(posedge clk) if (fifo_pop && feed.size() > 0) void'(feed.pop_front());
    always @(negedge clk) begin
        fifo_empty = (feed.size() == 0);
        fifo_data  = (feed.size() > 0) ? feed[0] : 16'h0;
    end

    // master-mode watcher
    always @(negedge clk) begin
        cyc++;
        if (mon_m) begin
            if (bclk_out != last_b) begin
                if (last_edge != 0 && !per_done) begin
                    chk(cyc - last_edge == dv + 1, "R2 bit-clock half period",
                        cyc - last_edge, dv + 1);
                    per_done = 1;
                end
                last_edge = cyc;
                if (bclk_out) observe(sdata_out, wclk_out);
            end
            last_b = bclk_out;
        end
    end

    task automatic run_case(input logic [1:0] al, input logic [1:0] ra, input bit wd,
                            input bit mo, input bit ms, input int div, input int nsamp,
                            input int nfr, input bit lb, input bit exp_under);
        @(negedge clk);
        tx_start = 0;
        cfg_align = al; cfg_ratio = ra; cfg_wide = wd; cfg_mono = mo;
        cfg_master = ms; cfg_div = 8'(div); cfg_loopback = lb;
        fr_len = (ra == 2'd1) ? 64 : (ra == 2'd2) ? 128 : 32;
        hlen = fr_len / 2; wbits = wd ? 16 : 8; dv = div;
        std_al = (al == 2'd0); rj_al = (al == 2'd2); mono_m = mo; lb_on = lb;
        bclk_in = 1; wclk_in = 1;
        tx_reset = 1;
        @(negedge clk);
        tx_reset = 0;
        feed.delete(); expq.delete();
        for (int i = 0; i < nsamp; i++) begin
            logic [15:0] v;
            v = 16'((i + 1) * 16'h1357) ^ 16'hA5C3 ^ {14'h0, al};
            feed.push_back(v);
            expq.push_back(wd ? v : {8'h00, v[7:0]});
        end
        prev_w = 1; have = 0; frames = 0; p = 0; per_done = 0; last_edge = 0;
        last_b = bclk_out; slave_clk_done = 0;
        repeat (3) @(negedge clk);
        mon_m = ms;
        tx_start = 1;
        if (ms) begin
            while (frames < nfr) @(negedge clk);
        end else begin
            repeat (4) @(negedge clk);
            for (int bc = 0; frames < nfr; bc++) begin
                bclk_in = 0;
                wclk_in = ((bc % fr_len) >= hlen);
                repeat (6) @(negedge clk);
                bclk_in = 1;
                observe(sdata_out, wclk_in);
                repeat (6) @(negedge clk);
            end
        end
        mon_m = 0;
        tx_start = 0;
        @(negedge clk);
        chk(underrun == exp_under, "R10 underrun flag", underrun, exp_under);
        if (exp_under) chk(expq.size() == 0, "R10 all samples sent in order", expq.size(), 0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(bclk_out == 1 && wclk_out == 1, "R1 idle clocks", {bclk_out, wclk_out}, 3);
        chk(sdata_out == 0 && fifo_pop == 0 && underrun == 0, "R1 idle data/pop/flag",
            {sdata_out, fifo_pop, underrun}, 0);
        // R12 loopback off passes the pin
        rx_sdata_pin = 1;
        @(negedge clk);
        chk(rx_sdata == 1, "R12 pin path", rx_sdata, 1);
        cfg_loopback = 1;
        @(negedge clk);
        chk(rx_sdata == 0, "R12 loopback selects data", rx_sdata, 0);
        cfg_loopback = 0; rx_sdata_pin = 0;

        // standard, 16-bit, stereo, 32 slots (LSB spill), drains into underrun
        run_case(2'd0, 2'd0, 1, 0, 1, 1, 3, 4, 0, 1);
        // R13 idle holds everything and tx_reset clears the flag
        begin
            int bad;
            bad = 0;
            feed.push_back(16'hFFFF);
            repeat (20) begin
                @(negedge clk);
                if (fifo_pop || sdata_out || !bclk_out) bad++;
            end
            chk(bad == 0, "R13 idle while stopped", bad, 0);
            chk(underrun == 1, "R10 flag sticky while stopped", underrun, 1);
            tx_reset = 1;
            @(negedge clk);
            tx_reset = 0;
            @(negedge clk);
            chk(underrun == 0, "R13 tx_reset clears flag", underrun, 0);
            feed.delete();
        end
        // left-justified, 8-bit, 64 slots, fastest divider, loopback on
        run_case(2'd1, 2'd1, 0, 0, 1, 0, 40, 3, 1, 0);
        // right-justified, 16-bit, 128 slots
        run_case(2'd2, 2'd2, 1, 0, 1, 2, 5, 4, 0, 1);
        // standard, 8-bit, mono, reserved ratio code acts as 32
        run_case(2'd0, 2'd3, 0, 1, 1, 1, 3, 5, 0, 1);
        // slave: left-justified 16-bit stereo, 64 slots
        run_case(2'd1, 2'd1, 1, 0, 0, 0, 4, 4, 0, 1);
        // slave: right-justified 8-bit mono, 32 slots
        run_case(2'd2, 2'd0, 0, 1, 0, 0, 40, 3, 0, 0);
        summary();
    end

endmodule